// File: doc/BRIEF.md
# Prioritized Response and Interrupt Framer

This block builds every frame that goes from the FPGA toward the host over a byte-wide bridge chip, which acts as a plain byte pipe. Four kinds of request can be pending at once:

- a header-error flag and a trailer-error flag, both raised by the incoming-frame decoder;
- a user interrupt, which comes with a status byte;
- a user read request, which comes with a length, a sub-address and a byte source.

Each request is latched until its frame has gone out completely. While the sequencer is idle, the highest-priority pending request is chosen and that frame is then emitted from start to finish. Every frame uses one common layout:

1. a fixed header byte;
2. a count byte holding the number of payload bytes minus one;
3. a direction/sub-address byte;
4. the payload;
5. a fixed trailer byte.

The host tells interrupts apart from data responses by the direction bit, which is 0 for an interrupt and 1 for a read response.

Bytes go to the bridge one per write strobe. A byte is only written when the bridge's active-low transmit-full flag reports free space. A write strobe is never held for two consecutive cycles, so the flag always has a cycle to react. For a read request, each payload byte drawn from the user source is acknowledged by a one-cycle pop strobe, and the source moves on to its next byte after that strobe.

Top module: `rfr_framer`

## Requirements
- R1: Every frame is, in order: header byte (default 0xA5), count byte equal to payload length minus one, direction/sub-address byte (bit 7 = direction, bits 6:0 = sub-address), payload, trailer byte (default 0x5A).
- R2: Interrupt frames have count byte 0x00, direction bit 0, and exactly one status byte as payload.
- R3: A header-error frame carries status 0x01 and a trailer-error frame carries status 0x02 (both parameters). Each carries the `last_sub_i` value present when its frame starts.
- R4: A user interrupt frame carries sub-address 0x7F and the `usr_status_i` value captured at the `usr_irq_i` pulse. Later changes to `usr_status_i` have no effect on that frame.
- R5: A read frame has direction bit 1, sub-address `rd_sub_i` and count `rd_len_i`, all captured at the `rd_req_i` pulse. Its payload is `rd_len_i`+1 bytes taken from `rd_data_i`, and each byte is followed by exactly one `rd_pop_o` pulse, which is asserted only together with `wr_o`.
- R6: When several requests are pending while the framer is idle, frames are sent in the order header error, trailer error, user interrupt, read request.
- R7: A request arriving during a frame never interrupts that frame. It stays pending and is served afterwards.
- R8: `wr_o` rises only after an edge at which `txe_n_i` was low. `wr_o` is high for one cycle per byte and never for two consecutive cycles.
- R9: During and after reset, with no requests, `wr_o` and `rd_pop_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_err_i | input | 1 | Header-error request pulse |
| trl_err_i | input | 1 | Trailer-error request pulse |
| last_sub_i | input | 7 | Sub-address of the latest host access |
| usr_irq_i | input | 1 | User interrupt request pulse |
| usr_status_i | input | 8 | User interrupt status byte |
| rd_req_i | input | 1 | User read request pulse |
| rd_len_i | input | 8 | Read length minus one |
| rd_sub_i | input | 7 | Read frame sub-address |
| rd_data_i | input | 8 | Current byte of the read source |
| rd_pop_o | output | 1 | Read source byte consumed |
| txe_n_i | input | 1 | Bridge transmit-full flag, low = space |
| wr_o | output | 1 | Bridge write strobe |
| dout_o | output | 8 | Byte to the bridge |

## Verification
A wrong payload counter shows at the ports within one frame, either as a missing or extra payload byte or as the trailer appearing in the wrong position. A wrong pending latch or priority decision shows as frames arriving in the wrong order, or as a frame missing, as soon as a contended set of requests has drained. The bench models the host side and rebuilds every expected frame arithmetically. It sweeps read lengths at both ends of the count range under a free-running and a throttled transmit flag.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
  // request kinds; lower value wins arbitration
  typedef enum logic [1:0] {K_HDR = 2'd0, K_TRL = 2'd1, K_USR = 2'd2, K_RD = 2'd3} kind_e;
  localparam int NKIND = 4;
  typedef enum logic [2:0] {S_IDLE, S_HEAD, S_CNT, S_DSUB, S_PAY, S_TAIL} st_e;
endpackage

// File: rtl/rfr_pending.sv
module rfr_pending
  import rfr_pkg::*;
#(
  parameter int NK = NKIND
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NK-1:0] set_i,
  input  logic [NK-1:0] clr_i,
  output logic [NK-1:0] pend_o,
  output kind_e         sel_o,
  output logic          any_o
);
  logic [NK-1:0] pend_q;

  generate
    for (genvar k = 0; k < NK; k++) begin : g_req
      always_ff @(posedge clk) begin
        if (rst)           pend_q[k] <= 1'b0;
        else if (set_i[k]) pend_q[k] <= 1'b1;
        else if (clr_i[k]) pend_q[k] <= 1'b0;
      end
    end
  endgenerate

  always_comb begin
    sel_o = K_RD;
    for (int k = NK - 1; k >= 0; k--) begin
      if (pend_q[k]) sel_o = kind_e'(2'(k));
    end
  end

  assign pend_o = pend_q;
  assign any_o  = |pend_q;
endmodule

// File: rtl/rfr_sequencer.sv
module rfr_sequencer
  import rfr_pkg::*;
#(
  parameter int          DW       = 8,
  parameter logic [DW-1:0] HDR_BYTE = 8'hA5,
  parameter logic [DW-1:0] TRL_BYTE = 8'h5A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any_i,
  input  kind_e         kind_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [DW-1:0] dsub_i,
  input  logic [DW-1:0] stat_i,
  input  logic [DW-1:0] data_i,
  input  logic          txe_n_i,
  output logic          idle_o,
  output kind_e         kind_o,
  output logic          done_o,
  output logic          wr_o,
  output logic          pop_o,
  output logic [DW-1:0] dout_o
);
  st_e           st_q;
  kind_e         kind_q;
  logic [DW-1:0] cnt_q, dsub_q, stat_q, left_q, dout_q, cur;
  logic          wr_q, pop_q, issue;

  assign issue = (st_q != S_IDLE) && !txe_n_i && !wr_q;

  always_comb begin
    unique case (st_q)
      S_HEAD:  cur = HDR_BYTE;
      S_CNT:   cur = cnt_q;
      S_DSUB:  cur = dsub_q;
      S_PAY:   cur = (kind_q == K_RD) ? data_i : stat_q;
      S_TAIL:  cur = TRL_BYTE;
      default: cur = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      kind_q <= K_HDR;
      cnt_q  <= '0;
      dsub_q <= '0;
      stat_q <= '0;
      left_q <= '0;
      wr_q   <= 1'b0;
      pop_q  <= 1'b0;
      dout_q <= '0;
    end else begin
      wr_q  <= issue;
      pop_q <= issue && (st_q == S_PAY) && (kind_q == K_RD);
      if (issue) dout_q <= cur;
      unique case (st_q)
        S_IDLE: if (any_i) begin
          st_q   <= S_HEAD;
          kind_q <= kind_i;
          cnt_q  <= cnt_i;
          dsub_q <= dsub_i;
          stat_q <= stat_i;
          left_q <= cnt_i;
        end
        S_HEAD: if (issue) st_q <= S_CNT;
        S_CNT:  if (issue) st_q <= S_DSUB;
        S_DSUB: if (issue) st_q <= S_PAY;
        S_PAY:  if (issue) begin
          if (left_q == '0) st_q <= S_TAIL;
          else              left_q <= left_q - 1'b1;
        end
        S_TAIL: if (issue) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign idle_o = (st_q == S_IDLE);
  assign kind_o = kind_q;
  assign done_o = issue && (st_q == S_TAIL);
  assign wr_o   = wr_q;
  assign pop_o  = pop_q;
  assign dout_o = dout_q;

  // R8
  wr_gate_chk: assert property (@(posedge clk) disable iff (rst) wr_q |-> $past(!txe_n_i));
  // R8
  wr_single_chk: assert property (@(posedge clk) disable iff (rst) wr_q |=> !wr_q);
  // R5
  pop_with_wr_chk: assert property (@(posedge clk) disable iff (rst) pop_q |-> wr_q);
  // R7
  kind_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != S_IDLE) && $past(st_q != S_IDLE) |-> $stable(kind_q));
endmodule

// File: rtl/rfr_framer.sv
module rfr_framer
  import rfr_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] HDR_BYTE = 8'hA5,
  parameter logic [DW-1:0] TRL_BYTE = 8'h5A,
  parameter logic [DW-1:0] ST_HDR   = 8'h01,
  parameter logic [DW-1:0] ST_TRL   = 8'h02
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hdr_err_i,
  input  logic          trl_err_i,
  input  logic [DW-2:0] last_sub_i,
  input  logic          usr_irq_i,
  input  logic [DW-1:0] usr_status_i,
  input  logic          rd_req_i,
  input  logic [DW-1:0] rd_len_i,
  input  logic [DW-2:0] rd_sub_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          rd_pop_o,
  input  logic          txe_n_i,
  output logic          wr_o,
  output logic [DW-1:0] dout_o
);
  localparam int            SW      = DW - 1;
  localparam logic [SW-1:0] USR_SUB = {SW{1'b1}};

  logic [DW-1:0] usr_st_q, rd_len_q;
  logic [SW-1:0] rd_sub_q;
  logic [NKIND-1:0] set_v, clr_v, pend;
  kind_e sel, cur_kind;
  logic any, done, idle;
  logic [DW-1:0] f_cnt, f_dsub, f_stat;

  always_ff @(posedge clk) begin
    if (rst) begin
      usr_st_q <= '0;
      rd_len_q <= '0;
      rd_sub_q <= '0;
    end else begin
      if (usr_irq_i) usr_st_q <= usr_status_i;
      if (rd_req_i) begin
        rd_len_q <= rd_len_i;
        rd_sub_q <= rd_sub_i;
      end
    end
  end

  assign set_v = {rd_req_i, usr_irq_i, trl_err_i, hdr_err_i};

  generate
    for (genvar k = 0; k < NKIND; k++) begin : g_clr
      assign clr_v[k] = done && (cur_kind == kind_e'(2'(k)));
    end
  endgenerate

  rfr_pending #(.NK(NKIND)) u_pend (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v),
    .pend_o(pend), .sel_o(sel), .any_o(any)
  );

  always_comb begin
    f_cnt  = (sel == K_RD) ? rd_len_q : '0;
    unique case (sel)
      K_HDR:   begin f_dsub = {1'b0, last_sub_i}; f_stat = ST_HDR;   end
      K_TRL:   begin f_dsub = {1'b0, last_sub_i}; f_stat = ST_TRL;   end
      K_USR:   begin f_dsub = {1'b0, USR_SUB};    f_stat = usr_st_q; end
      default: begin f_dsub = {1'b1, rd_sub_q};   f_stat = '0;       end
    endcase
  end

  rfr_sequencer #(.DW(DW), .HDR_BYTE(HDR_BYTE), .TRL_BYTE(TRL_BYTE)) u_seq (
    .clk(clk), .rst(rst), .any_i(any), .kind_i(sel),
    .cnt_i(f_cnt), .dsub_i(f_dsub), .stat_i(f_stat), .data_i(rd_data_i),
    .txe_n_i(txe_n_i), .idle_o(idle), .kind_o(cur_kind), .done_o(done),
    .wr_o(wr_o), .pop_o(rd_pop_o), .dout_o(dout_o)
  );

  // R6
  prio_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    idle && pend[K_HDR] |=> cur_kind == K_HDR);
  // R6
  prio_rd_last_chk: assert property (@(posedge clk) disable iff (rst)
    idle && pend[K_RD] && (pend[K_HDR] || pend[K_TRL] || pend[K_USR]) |=> cur_kind != K_RD);
endmodule

// File: tb/tb_rfr_framer.sv
module tb_rfr_framer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hdr_err_i = 0, trl_err_i = 0, usr_irq_i = 0, rd_req_i = 0;
  logic [6:0] last_sub_i = '0, rd_sub_i = '0;
  logic [7:0] usr_status_i = '0, rd_len_i = '0, rd_data_i;
  logic txe_n_i = 1'b0;
  logic rd_pop_o, wr_o;
  logic [7:0] dout_o;

  always #4 clk = ~clk;

  rfr_framer dut (
    .clk(clk), .rst(rst), .hdr_err_i(hdr_err_i), .trl_err_i(trl_err_i),
    .last_sub_i(last_sub_i), .usr_irq_i(usr_irq_i), .usr_status_i(usr_status_i),
    .rd_req_i(rd_req_i), .rd_len_i(rd_len_i), .rd_sub_i(rd_sub_i),
    .rd_data_i(rd_data_i), .rd_pop_o(rd_pop_o), .txe_n_i(txe_n_i),
    .wr_o(wr_o), .dout_o(dout_o)
  );

  int checks = 0, bad = 0;
  int cyc = 0, txe_mode = 0, viol = 0;
  int src_idx = 0, exp_idx = 0;
  int rx_n = 0, exp_n = 0;
  logic [7:0] rx [0:2047];
  logic [7:0] ex [0:2047];
  logic prev_txe = 1'b0, prev_wr = 1'b0;

  function automatic logic [7:0] src_byte(input int i);
    return 8'(i * 7 + 3);
  endfunction

  assign rd_data_i = src_byte(src_idx);

  // host model, transmit-flag generator, source model, watchdog
  always @(negedge clk) begin
    logic nt;
    cyc++;
    if (wr_o) begin
      if (prev_txe) viol++;
      if (prev_wr) viol++;
      if (rx_n < 2048) rx[rx_n] = dout_o;
      rx_n++;
    end
    if (rd_pop_o) src_idx++;
    prev_wr = wr_o;
    nt = (txe_mode == 0) ? 1'b0 : (txe_mode == 2) ? 1'b1 : ((cyc % 3) == 1);
    prev_txe = nt;
    txe_n_i = nt;
    if (cyc > 150000) begin
      checks++; bad++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic push(input logic [7:0] b);
    ex[exp_n] = b;
    exp_n++;
  endtask

  task automatic exp_irq(input logic [6:0] sub, input logic [7:0] st);
    push(8'hA5); push(8'h00); push({1'b0, sub}); push(st); push(8'h5A);
  endtask

  task automatic exp_rd(input logic [6:0] sub, input logic [7:0] len);
    push(8'hA5); push(len); push({1'b1, sub});
    for (int i = 0; i <= int'(len); i++) begin
      push(src_byte(exp_idx));
      exp_idx++;
    end
    push(8'h5A);
  endtask

  task automatic check_frames(input string tag);
    int t = 0;
    logic ok = 1'b1;
    while (rx_n < exp_n && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (30) @(negedge clk);
    checks++;
    if (rx_n != exp_n) begin
      ok = 1'b0;
      $display("FAIL %s: byte count actual=%0d expected=%0d", tag, rx_n, exp_n);
    end else begin
      for (int i = 0; i < exp_n; i++) begin
        if (ok && rx[i] !== ex[i]) begin
          ok = 1'b0;
          $display("FAIL %s: byte %0d actual=%02h expected=%02h", tag, i, rx[i], ex[i]);
        end
      end
    end
    if (!ok) bad++;
    rx_n = 0;
    exp_n = 0;
  endtask

  task automatic fire(input logic h, input logic t, input logic u, input logic r);
    @(negedge clk);
    hdr_err_i = h; trl_err_i = t; usr_irq_i = u; rd_req_i = r;
    @(negedge clk);
    hdr_err_i = 0; trl_err_i = 0; usr_irq_i = 0; rd_req_i = 0;
  endtask

  initial begin
    logic rst_ok = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (wr_o !== 1'b0 || rd_pop_o !== 1'b0) rst_ok = 1'b0;
    end
    // R9: outputs quiet during reset
    checks++;
    if (!rst_ok) begin
      bad++;
      $display("FAIL R9 reset: wr=%b pop=%b expected 0 0", wr_o, rd_pop_o);
    end
    rst = 1'b0;
    repeat (20) @(negedge clk);
    // R9: nothing sent with no requests
    checks++;
    if (rx_n != 0) begin
      bad++;
      $display("FAIL R9 idle: bytes actual=%0d expected=0", rx_n);
    end

    // R4 R2: user interrupt
    usr_status_i = 8'h3C;
    fire(0, 0, 1, 0);
    usr_status_i = 8'h00;
    exp_irq(7'h7F, 8'h3C);
    check_frames("R4 user interrupt");

    // R3: header-error frame
    last_sub_i = 7'h15;
    fire(1, 0, 0, 0);
    exp_irq(7'h15, 8'h01);
    check_frames("R3 header error");

    // R3: trailer-error frame
    last_sub_i = 7'h2A;
    fire(0, 1, 0, 0);
    exp_irq(7'h2A, 8'h02);
    check_frames("R3 trailer error");

    // R5 R1: read frames over lengths and transmit-flag patterns
    for (int m = 0; m < 2; m++) begin
      for (int j = 0; j < 4; j++) begin
        logic [7:0] len;
        len = (j == 0) ? 8'd0 : (j == 1) ? 8'd1 : (j == 2) ? 8'd7 : 8'd255;
        txe_mode = m;
        rd_len_i = len;
        rd_sub_i = 7'(len + 5);
        fire(0, 0, 0, 1);
        rd_len_i = 8'h00;
        rd_sub_i = 7'h00;
        exp_rd(7'(len + 5), len);
        check_frames($sformatf("R5 read len=%0d mode=%0d", len, m));
      end
    end

    // R6: all four pending together
    txe_mode = 2;
    last_sub_i = 7'h0F;
    usr_status_i = 8'h99;
    rd_len_i = 8'd3;
    rd_sub_i = 7'h33;
    fire(1, 1, 1, 1);
    usr_status_i = 8'h00;
    repeat (5) @(negedge clk);
    txe_mode = 0;
    exp_irq(7'h0F, 8'h01);
    exp_irq(7'h0F, 8'h02);
    exp_irq(7'h7F, 8'h99);
    exp_rd(7'h33, 8'd3);
    check_frames("R6 priority order");

    // R7: header error raised mid read frame waits for the frame to end
    txe_mode = 1;
    rd_len_i = 8'd15;
    rd_sub_i = 7'h22;
    fire(0, 0, 0, 1);
    repeat (12) @(negedge clk);
    last_sub_i = 7'h40;
    fire(1, 0, 0, 0);
    exp_rd(7'h22, 8'd15);
    exp_irq(7'h40, 8'h01);
    check_frames("R7 no preemption");

    // R8: write strobe discipline over the whole run
    checks++;
    if (viol != 0) begin
      bad++;
      $display("FAIL R8 strobe violations actual=%0d expected=0", viol);
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule